// File: doc/BRIEF.md
# Object Memory Page DMA

This block copies one 256-byte page of processor-visible memory into the 256-byte object attribute memory. The processor starts it with a single write to a trigger register. The byte it writes names the source page: the page starts at that byte times 256, and the three most significant bits pick the memory region that supplies it. While the copy runs, a busy output stalls the processor.

The engine reads the source through a synchronous memory port with one cycle of read latency. It issues one read per cycle and writes each returned byte into the object memory in the next cycle. Each region has its own address width, so the source offset is folded to that width. Work RAM repeats every 2 KB. Save RAM and the four ROM banks repeat every 8 KB. Two region codes select register space, and a trigger with either code moves nothing.

Top module: `objpage_dma`

## Requirements
- R1: After reset, busy, src_re and obj_we are low and trig_rdata reads 0x00.
- R2: A trigger write accepted while busy is low stores the written byte. trig_rdata shows that byte from the following cycle.
- R3: Region code 0 (bits 7:5 of the byte) selects work RAM. src_bank is 0 and src_offs is ((byte*256)+index) modulo 2048.
- R4: Region code 3 selects save RAM. src_bank is 3 and src_offs is ((byte*256)+index) modulo 8192.
- R5: Region codes 4 to 7 select ROM banks 0 to 3. src_bank equals the code and src_offs is ((byte*256)+index) modulo 8192.
- R6: Region codes 1 and 2 start no transfer. busy stays low and no source read or object write occurs, but the byte is still stored for readback.
- R7: A transfer makes exactly 256 object writes, one per cycle, to obj_addr 0, 1, ... 255 in that order.
- R8: Each object write takes place in the cycle after the source read for the same index. Its data is the value src_rdata returns for that read.
- R9: busy rises in the cycle after an accepted copying trigger. It stays high for 257 cycles, up to and including the cycle of the last object write.
- R10: A trigger write while busy is high is ignored. The readback value and the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Processor write strobe for the trigger register |
| trig_wdata | input | 8 | Byte written to the trigger register |
| trig_rdata | output | 8 | Stored trigger byte for readback |
| busy | output | 1 | Transfer in progress; stalls the processor |
| src_re | output | 1 | Source read request |
| src_bank | output | 3 | Source region code (0 work RAM, 3 save RAM, 4-7 ROM bank 0-3) |
| src_offs | output | 13 | Folded source offset within the region |
| src_rdata | input | 8 | Source read data, valid one cycle after src_re |
| obj_we | output | 1 | Object memory write strobe |
| obj_addr | output | 8 | Object memory write address |
| obj_wdata | output | 8 | Object memory write data |

## Verification
A wrong index counter shows up on src_offs in the same cycle as the faulty read. One cycle later it shows up on obj_addr, which breaks the ascending write order. A region decode or fold error changes src_bank or src_offs on the very first read of a transfer. A stale active or write-stage flag shows as a busy pulse that is not exactly 257 cycles long, or as a write with no read before it. Triggers in register space and triggers while busy are checked by watching for unwanted port activity and for a changed readback value.

// File: rtl/objdma_pkg.sv
package objdma_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned OFFS_W  = 13;
  localparam int unsigned WRAM_AW = 11;

  typedef enum logic [CODE_W-1:0] {
    RG_WRAM = 3'd0, RG_REGA = 3'd1, RG_REGB = 3'd2, RG_SAVE = 3'd3,
    RG_ROM0 = 3'd4, RG_ROM1 = 3'd5, RG_ROM2 = 3'd6, RG_ROM3 = 3'd7
  } region_e;

  function automatic region_e region_of(input logic [BYTE_W-1:0] page);
    return region_e'(page[BYTE_W-1 -: CODE_W]);
  endfunction

  function automatic logic region_copies(input region_e rg);
    return !(rg == RG_REGA || rg == RG_REGB);
  endfunction

  function automatic logic [OFFS_W-1:0] fold_offs(input logic [BYTE_W-1:0] page,
                                                  input logic [IDX_W-1:0]  idx);
    logic [BYTE_W+IDX_W-1:0] lin;
    lin = {page, idx};
    if (region_of(page) == RG_WRAM)
      return OFFS_W'(lin[WRAM_AW-1:0]);
    return lin[OFFS_W-1:0];
  endfunction
endpackage

// File: rtl/objdma_trigger.sv
module objdma_trigger
  import objdma_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_we,
  input  logic [DW-1:0] trig_wdata,
  input  logic          busy,
  output logic [DW-1:0] page_q,
  output logic          start
);
  logic accept;

  assign accept = trig_we && !busy;
  assign start  = accept && region_copies(region_of(trig_wdata));

  always_ff @(posedge clk) begin
    if (!rst_n)      page_q <= '0;
    else if (accept) page_q <= trig_wdata;
  end
endmodule

// File: rtl/objdma_reader.sv
module objdma_reader
  import objdma_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CODE_W,
  parameter int unsigned OW = OFFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] page,
  output logic          src_re,
  output logic [CW-1:0] src_bank,
  output logic [OW-1:0] src_offs,
  output logic [IW-1:0] rd_idx,
  output logic          last_rd
);
  localparam logic [IW-1:0] LAST_IDX = '1;

  logic          active_q;
  logic [IW-1:0] idx_q;

  assign src_re   = active_q;
  assign rd_idx   = idx_q;
  assign last_rd  = active_q && (idx_q == LAST_IDX);
  assign src_bank = page[DW-1 -: CW];
  assign src_offs = fold_offs(page, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      idx_q <= idx_q + 1'b1;
      if (last_rd) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/objdma_writer.sv
module objdma_writer
  import objdma_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_addr,
  output logic          last_wr
);
  localparam logic [IW-1:0] LAST_IDX = '1;

  logic          wr_q;
  logic [IW-1:0] addr_q;

  assign wr_en   = wr_q;
  assign wr_addr = addr_q;
  assign last_wr = wr_q && (addr_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q   <= rd_fire;
      addr_q <= rd_idx;
    end
  end
endmodule

// File: rtl/objpage_dma.sv
module objpage_dma
  import objdma_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CODE_W,
  parameter int unsigned OW = OFFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_we,
  input  logic [DW-1:0] trig_wdata,
  output logic [DW-1:0] trig_rdata,
  output logic          busy,
  output logic          src_re,
  output logic [CW-1:0] src_bank,
  output logic [OW-1:0] src_offs,
  input  logic [DW-1:0] src_rdata,
  output logic          obj_we,
  output logic [IW-1:0] obj_addr,
  output logic [DW-1:0] obj_wdata
);
  logic          start_w;
  logic          last_rd_w;
  logic          last_wr_w;
  logic          rd_fire_w;
  logic [IW-1:0] rd_idx_w;
  logic [DW-1:0] page_w;

  assign trig_rdata = page_w;
  assign src_re     = rd_fire_w;
  assign busy       = rd_fire_w | obj_we;
  assign obj_wdata  = src_rdata;

  objdma_trigger #(.DW(DW)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .busy(busy), .page_q(page_w), .start(start_w)
  );

  objdma_reader #(.DW(DW), .IW(IW), .CW(CW), .OW(OW)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(start_w), .page(page_w),
    .src_re(rd_fire_w), .src_bank(src_bank), .src_offs(src_offs),
    .rd_idx(rd_idx_w), .last_rd(last_rd_w)
  );

  objdma_writer #(.IW(IW)) u_wr (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire_w), .rd_idx(rd_idx_w),
    .wr_en(obj_we), .wr_addr(obj_addr), .last_wr(last_wr_w)
  );
endmodule

// File: rtl/objpage_dma_chk.sv
module objpage_dma_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_we,
  input logic [DW-1:0] trig_wdata,
  input logic [DW-1:0] trig_rdata,
  input logic          busy,
  input logic          src_re,
  input logic          obj_we,
  input logic [IW-1:0] obj_addr,
  input logic          start_evt,
  input logic          last_wr
);
  logic [CW-1:0] code_w;
  assign code_w = trig_wdata[DW-1 -: CW];

  a_r9_activity_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (src_re || obj_we) |-> busy);
  a_r9_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  a_r9_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> !busy);
  a_r7_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_we && !$past(obj_we)) |-> (obj_addr == '0));
  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_we && $past(obj_we)) |-> (obj_addr == $past(obj_addr) + 1'b1));
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    obj_we == $past(src_re));
  a_r10_busy_trigger_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && busy) |=> (trig_rdata == $past(trig_rdata)));
  a_r6_hole_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !busy && (code_w == 3'd1 || code_w == 3'd2)) |=> !busy);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !busy) |=> (trig_rdata == $past(trig_wdata)));
endmodule

bind objpage_dma objpage_dma_chk #(.DW(DW), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
  .trig_rdata(trig_rdata), .busy(busy), .src_re(src_re), .obj_we(obj_we),
  .obj_addr(obj_addr), .start_evt(start_w), .last_wr(last_wr_w)
);

// File: tb/objpage_dma_tb_top.sv
`timescale 1ns/1ps
module objpage_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [7:0]  trig_wdata = '0;
  logic [7:0]  trig_rdata;
  logic        busy;
  logic        src_re;
  logic [2:0]  src_bank;
  logic [12:0] src_offs;
  logic [7:0]  src_rdata = '0;
  logic        obj_we;
  logic [7:0]  obj_addr;
  logic [7:0]  obj_wdata;

  int checks = 0;
  int fails  = 0;
  int rd_seen, wr_seen, busy_cnt, rd_err, wr_err;
  logic [7:0] cur_v = '0;

  always #2 clk = ~clk;

  objpage_dma dut_i (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .trig_rdata(trig_rdata), .busy(busy), .src_re(src_re), .src_bank(src_bank),
    .src_offs(src_offs), .src_rdata(src_rdata), .obj_we(obj_we),
    .obj_addr(obj_addr), .obj_wdata(obj_wdata)
  );

  // Expected source offset: linear byte address reduced by the region size.
  function automatic logic [12:0] exp_offs(input logic [7:0] v, input int i);
    int lin;
    lin = int'(v) * 256 + i;
    if (v[7:5] == 3'd0) return 13'(lin % 2048);
    return 13'(lin % 8192);
  endfunction

  // Content of the modelled source memories.
  function automatic logic [7:0] mdata(input logic [2:0] b, input logic [12:0] o);
    int x;
    x = (int'(o) * 7) ^ (int'(o) >> 5) ^ (int'(b) * 53);
    return 8'(x);
  endfunction

  function automatic string region_tag(input logic [7:0] v);
    case (v[7:5])
      3'd0: return "R3";
      3'd3: return "R4";
      3'd1, 3'd2: return "R6";
      default: return "R5";
    endcase
  endfunction

  always_ff @(posedge clk)
    if (src_re) src_rdata <= mdata(src_bank, src_offs);

  always @(negedge clk) begin
    if (rst_n) begin
      if (src_re) begin
        if (src_bank != cur_v[7:5] || src_offs != exp_offs(cur_v, rd_seen)) rd_err++;
        rd_seen++;
      end
      if (obj_we) begin
        if (int'(obj_addr) != wr_seen ||
            obj_wdata != mdata(cur_v[7:5], exp_offs(cur_v, wr_seen))) wr_err++;
        wr_seen++;
      end
      if (busy) busy_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rd_seen = 0; wr_seen = 0; busy_cnt = 0; rd_err = 0; wr_err = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 700 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_trig(input logic [7:0] v);
    trig_we = 1'b1; trig_wdata = v;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic run_page(input logic [7:0] v, input bit cp);
    string tg;
    tg = region_tag(v);
    @(negedge clk);
    clear_mon();
    cur_v = v;
    pulse_trig(v);
    wait_idle();
    check(trig_rdata == v, "R2", "readback", int'(trig_rdata), int'(v));
    check(rd_seen == (cp ? 256 : 0), tg, "read count", rd_seen, cp ? 256 : 0);
    check(rd_err == 0, tg, "bad bank/offset reads", rd_err, 0);
    check(wr_seen == (cp ? 256 : 0), "R7", "write count", wr_seen, cp ? 256 : 0);
    check(wr_err == 0, "R8", "bad write addr/data", wr_err, 0);
    check(busy_cnt == (cp ? 257 : 0), "R9", "busy cycles", busy_cnt, cp ? 257 : 0);
  endtask

  // {copy expected, trigger byte}
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 8'h00}, {1'b1, 8'h07}, {1'b1, 8'h1F}, {1'b0, 8'h20},
    {1'b0, 8'h5A}, {1'b1, 8'h60}, {1'b1, 8'h7F}, {1'b1, 8'h80},
    {1'b1, 8'hA3}, {1'b1, 8'hC5}, {1'b1, 8'hFF}, {1'b0, 8'h3F}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!src_re, "R1", "src_re after reset", int'(src_re), 0);
    check(!obj_we, "R1", "obj_we after reset", int'(obj_we), 0);
    check(trig_rdata == 8'h00, "R1", "readback after reset", int'(trig_rdata), 0);

    for (int n = 0; n < 12; n++) run_page(VEC[n][7:0], VEC[n][8]);

    // R10: trigger during a transfer is ignored
    @(negedge clk);
    clear_mon();
    cur_v = 8'h80;
    pulse_trig(8'h80);
    repeat (10) @(negedge clk);
    pulse_trig(8'hC3);
    wait_idle();
    check(trig_rdata == 8'h80, "R10", "readback after busy trigger", int'(trig_rdata), 8'h80);
    check(wr_seen == 256, "R10", "writes after busy trigger", wr_seen, 256);
    check(wr_err == 0 && rd_err == 0, "R10", "transfer disturbed", wr_err + rd_err, 0);
    check(busy_cnt == 257, "R10", "busy cycles with busy trigger", busy_cnt, 257);

    // R6 then immediate copy: register-space trigger leaves no trace
    run_page(8'h40, 1'b0);
    run_page(8'hE0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule